// File: doc/BRIEF.md
# Programmable Pulse-Swallow Clock Divider

This block divides a fast input clock by a programmable integer ratio N = M·P + A and produces one single-cycle pulse every N input cycles. A small prescaler stage counts input cycles and switches between a modulus of P and P+1 under a control signal. Two slower counters advance only when the prescaler completes a cycle. The program counter spans M prescaler cycles. The swallow counter holds the prescaler at P+1 for the first A of them. Only the prescaler has to compare on every input cycle. Both counters see one enable per prescaler cycle.

Software or a control block presents M and A with a one-cycle write strobe. A setting is legal when M is at least 1 and A does not exceed M. A legal setting is staged and loaded into the counters at the next output-cycle boundary, so the period in progress always completes at its old ratio. An illegal setting is discarded and raises an error flag. The last legal setting stays in force. The whole block runs on one clock. The slow counters use the prescaler's completion as a clock enable.

Top module: `pulse_swallow_div`

## Requirements
- R1: With staged values M (1 ≤ M) and A (0 ≤ A ≤ M), consecutive rising edges of `div_pulse` are exactly M·P + A input clock cycles apart, and the spacing repeats unchanged while no new setting is written.
- R2: In each output period the prescaler divides by P+1 for its first A cycles and by P for the remaining M−A. As a result, A = 0 gives M·P and A = M gives M·(P+1).
- R3: `div_pulse` is high for exactly one clock cycle per output period, and only in the cycle that follows a prescaler completion.
- R4: A write (`cfg_wr` = 1) with `cfg_m` = 0 or `cfg_a` > `cfg_m` sets `cfg_err` in the next cycle and leaves the division ratio of all following periods unchanged.
- R5: A write with `cfg_m` ≥ 1 and `cfg_a` ≤ `cfg_m` clears `cfg_err` in the next cycle and stages the new values.
- R6: Staged values are loaded only at an output-period boundary. The period in progress when a write occurs, at any point within it, completes with the old ratio, and the following period uses the new one.
- R7: During and after synchronous reset `div_pulse` and `cfg_err` are 0 and the setting is RST_M/RST_A. The first pulse after reset is released comes RST_M·P + RST_A cycles later (17 with defaults P=4, RST_M=4, RST_A=1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Full-rate input clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | One-cycle strobe that presents a new setting |
| cfg_m | input | CNT_W | Program count M (prescaler cycles per output period) |
| cfg_a | input | CNT_W | Swallow count A (prescaler cycles at P+1) |
| cfg_err | output | 1 | High after a rejected setting, cleared by a legal one |
| div_pulse | output | 1 | Registered one-cycle pulse once per output period |

## Verification
The ratio is tried with a vector table that covers the extremes: A = 0 (all cycles at P), A = M (all at P+1), M = 1 (the shortest period, where one prescaler cycle is also the terminal one), the largest M, and mid-range mixes. Seeded random legal pairs are added to these. Comparing the A = 0 and A = M results against mixed values shows whether the swallow counter applies the P+1 modulus to the right number of prescaler cycles. After every write the old period is measured again, and a directed write placed mid-period shows whether a new setting leaks into a period already running. Rejected settings (A > M, M = 0) are followed by two measured periods, which shows that the flag rises and the ratio stays the same. A reset placed after a staged change shows that the defaults return.

// File: rtl/psd_pkg.sv
`timescale 1ns/1ps
package psd_pkg;
  // Prescaler modulus selection driven by the swallow counter.
  typedef enum logic {
    MOD_BASE = 1'b0,  // divide by P
    MOD_EXT  = 1'b1   // divide by P+1
  } mod_sel_e;
endpackage

// File: rtl/psd_prescaler.sv
`timescale 1ns/1ps
module psd_prescaler #(
  parameter int P = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  psd_pkg::mod_sel_e  mod_sel_i,
  output logic               tick_o
);
  localparam int CW = $clog2(P + 2);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last_c;

  // Terminal count depends on the modulus requested for this cycle.
  always_comb begin
    if (mod_sel_i == psd_pkg::MOD_EXT) last_c = CW'(P);
    else                               last_c = CW'(P - 1);
  end

  assign tick_o = (cnt_q == last_c);

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/psd_cfg_reg.sv
`timescale 1ns/1ps
module psd_cfg_reg #(
  parameter int CNT_W = 6,
  parameter int RST_M = 4,
  parameter int RST_A = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] m_i,
  input  logic [CNT_W-1:0] a_i,
  output logic [CNT_W-1:0] stage_m_o,
  output logic [CNT_W-1:0] stage_a_o,
  output logic             err_o
);
  logic legal_c;

  assign legal_c = (m_i != '0) && (a_i <= m_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_m_o <= CNT_W'(RST_M);
      stage_a_o <= CNT_W'(RST_A);
      err_o     <= 1'b0;
    end else if (wr_i) begin
      if (legal_c) begin
        stage_m_o <= m_i;
        stage_a_o <= a_i;
        err_o     <= 1'b0;
      end else begin
        err_o     <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/psd_counters.sv
`timescale 1ns/1ps
module psd_counters #(
  parameter int CNT_W = 6,
  parameter int RST_M = 4,
  parameter int RST_A = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_i,
  input  logic [CNT_W-1:0]   stage_m_i,
  input  logic [CNT_W-1:0]   stage_a_i,
  output psd_pkg::mod_sel_e  mod_sel_o,
  output logic               pulse_o
);
  logic [CNT_W-1:0] prog_q;   // prescaler cycles left in this period
  logic [CNT_W-1:0] swal_q;   // extended cycles left in this period
  logic             last_c;

  assign last_c    = (prog_q == CNT_W'(1));
  assign mod_sel_o = (swal_q != '0) ? psd_pkg::MOD_EXT : psd_pkg::MOD_BASE;

  always_ff @(posedge clk) begin
    if (rst) begin
      prog_q  <= CNT_W'(RST_M);
      swal_q  <= CNT_W'(RST_A);
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= tick_i && last_c;
      if (tick_i) begin
        if (last_c) begin
          prog_q <= stage_m_i;
          swal_q <= stage_a_i;
        end else begin
          prog_q <= prog_q - 1'b1;
          if (swal_q != '0) swal_q <= swal_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pulse_swallow_div.sv
`timescale 1ns/1ps
module pulse_swallow_div #(
  parameter int P     = 4,
  parameter int CNT_W = 6,
  parameter int RST_M = 4,
  parameter int RST_A = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [CNT_W-1:0] cfg_m,
  input  logic [CNT_W-1:0] cfg_a,
  output logic             cfg_err,
  output logic             div_pulse
);
  psd_pkg::mod_sel_e mod_sel;
  logic              pre_tick;
  logic [CNT_W-1:0]  stage_m;
  logic [CNT_W-1:0]  stage_a;

  psd_prescaler #(.P(P)) presc_i (
    .clk       (clk),
    .rst       (rst),
    .mod_sel_i (mod_sel),
    .tick_o    (pre_tick)
  );

  psd_cfg_reg #(.CNT_W(CNT_W), .RST_M(RST_M), .RST_A(RST_A)) cfg_i (
    .clk       (clk),
    .rst       (rst),
    .wr_i      (cfg_wr),
    .m_i       (cfg_m),
    .a_i       (cfg_a),
    .stage_m_o (stage_m),
    .stage_a_o (stage_a),
    .err_o     (cfg_err)
  );

  psd_counters #(.CNT_W(CNT_W), .RST_M(RST_M), .RST_A(RST_A)) cnt_i (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (pre_tick),
    .stage_m_i (stage_m),
    .stage_a_i (stage_a),
    .mod_sel_o (mod_sel),
    .pulse_o   (div_pulse)
  );
endmodule

// File: rtl/psd_checker.sv
`timescale 1ns/1ps
module psd_checker #(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_wr,
  input logic [CNT_W-1:0] cfg_m,
  input logic [CNT_W-1:0] cfg_a,
  input logic             cfg_err,
  input logic             div_pulse,
  input logic             pre_tick,
  input logic             mod_sel
);
  // R3: the pulse lasts one cycle
  a_r3_one_cycle_pulse: assert property (@(posedge clk) disable iff (rst)
    div_pulse |=> !div_pulse);

  // R3: a pulse follows a prescaler completion
  a_r3_pulse_after_tick: assert property (@(posedge clk) disable iff (rst)
    div_pulse |-> $past(pre_tick));

  // R2: the modulus only changes when a prescaler cycle ends
  a_r2_mod_held: assert property (@(posedge clk) disable iff (rst)
    !pre_tick |=> $stable(mod_sel));

  // R4: a rejected write raises the flag
  a_r4_reject_flag: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && ((cfg_m == '0) || (cfg_a > cfg_m))) |=> cfg_err);

  // R5: an accepted write clears the flag
  a_r5_accept_clear: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && (cfg_m != '0) && (cfg_a <= cfg_m)) |=> !cfg_err);

  // R4: without a write the flag holds
  a_r4_flag_hold: assert property (@(posedge clk) disable iff (rst)
    !cfg_wr |=> $stable(cfg_err));
endmodule

bind pulse_swallow_div psd_checker #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .cfg_wr    (cfg_wr),
  .cfg_m     (cfg_m),
  .cfg_a     (cfg_a),
  .cfg_err   (cfg_err),
  .div_pulse (div_pulse),
  .pre_tick  (pre_tick),
  .mod_sel   (mod_sel)
);

// File: tb/pulse_swallow_div_tb_top.sv
`timescale 1ns/1ps
module pulse_swallow_div_tb_top;
  localparam int P     = 4;
  localparam int CNT_W = 6;
  localparam int RST_M = 4;
  localparam int RST_A = 1;
  localparam int NVEC  = 10;

  // Each entry: {M, A}
  localparam logic [2*CNT_W-1:0] VEC [NVEC] = '{
    {6'd1,  6'd0},  {6'd1,  6'd1},  {6'd2,  6'd0},  {6'd2,  6'd2},
    {6'd5,  6'd3},  {6'd7,  6'd0},  {6'd10, 6'd10}, {6'd63, 6'd0},
    {6'd63, 6'd63}, {6'd20, 6'd7}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cfg_wr = 1'b0;
  logic [CNT_W-1:0] cfg_m = '0;
  logic [CNT_W-1:0] cfg_a = '0;
  logic             cfg_err;
  logic             div_pulse;

  int checks = 0;
  int fails  = 0;
  int cur_n  = RST_M * P + RST_A;

  always #4 clk = ~clk;

  pulse_swallow_div #(.P(P), .CNT_W(CNT_W), .RST_M(RST_M), .RST_A(RST_A)) dut_i (
    .clk (clk), .rst (rst), .cfg_wr (cfg_wr), .cfg_m (cfg_m), .cfg_a (cfg_a),
    .cfg_err (cfg_err), .div_pulse (div_pulse)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Counts negedges until div_pulse is seen, starting from 'already'.
  task automatic next_gap(input int already, output int gap);
    gap = already;
    do begin
      @(negedge clk);
      gap++;
    end while (!div_pulse);
  endtask

  // Drives a one-cycle write from a negedge; returns at the next negedge.
  task automatic write_cfg(input int m, input int a);
    cfg_m  = CNT_W'(m);
    cfg_a  = CNT_W'(a);
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic run_pair(input int m, input int a, input string tag);
    int g;
    int exp;
    exp = m * P + a;
    write_cfg(m, a);
    chk({tag, " R5 err clear"}, int'(cfg_err), 0);
    next_gap(1, g);
    chk({tag, " R6 old period"}, g, cur_n);
    @(negedge clk);
    chk({tag, " R3 pulse width"}, int'(div_pulse), 0);
    next_gap(1, g);
    chk({tag, " R1/R2 new period"}, g, exp);
    cur_n = exp;
  endtask

  initial begin
    int g;
    repeat (3) @(negedge clk);
    chk("R7 reset pulse low", int'(div_pulse), 0);
    chk("R7 reset err low", int'(cfg_err), 0);
    rst = 1'b0;
    next_gap(0, g);
    chk("R7 first period", g, RST_M * P + RST_A);
    next_gap(0, g);
    chk("R1 repeat period", g, cur_n);

    for (int i = 0; i < NVEC; i++)
      run_pair(int'(VEC[i][2*CNT_W-1:CNT_W]), int'(VEC[i][CNT_W-1:0]), "table");

    for (int i = 0; i < 4; i++) begin
      int m;
      int a;
      m = int'($urandom_range(63, 1));
      a = int'($urandom_range(m, 0));
      run_pair(m, a, "random");
    end

    // R4: A greater than M is rejected
    write_cfg(3, 5);
    chk("R4 flag on A>M", int'(cfg_err), 1);
    next_gap(1, g);
    chk("R4 ratio kept 1", g, cur_n);
    next_gap(0, g);
    chk("R4 ratio kept 2", g, cur_n);
    // R4: M of zero is rejected
    write_cfg(0, 0);
    chk("R4 flag on M=0", int'(cfg_err), 1);
    next_gap(1, g);
    chk("R4 ratio kept 3", g, cur_n);
    // R5: legal write clears the flag
    run_pair(2, 1, "after reject");

    // R6: write placed in the middle of a period
    repeat (4) @(negedge clk);
    write_cfg(4, 4);
    next_gap(5, g);
    chk("R6 mid-period old ratio", g, cur_n);
    next_gap(0, g);
    chk("R6 mid-period new ratio", g, 20);
    cur_n = 20;

    // R7: reset restores defaults even with a staged change pending
    write_cfg(9, 2);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 re-reset pulse low", int'(div_pulse), 0);
    rst = 1'b0;
    next_gap(0, g);
    chk("R7 defaults after re-reset", g, RST_M * P + RST_A);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule